// File: doc/BRIEF.md
# Real-Mode Address Generator with A20 Gate

This block builds the 21-bit physical address that an 8086-compatible core uses in real mode. A 16-bit segment value is moved up four bit positions to make a 20-bit base, and a 16-bit offset is added to that base. The sum can carry into bit 20. A gate input then either keeps that carry or clears it. Clearing it gives the old 1 MB wraparound. Keeping it makes the high memory area, 0x100000 to 0x10FFEF, reachable.

The same unit also computes where an interrupt vector's table entry sits. The table starts at physical address 0 and ends at 0x3FF. Each entry is 4 bytes: the handler offset comes first, then its segment. A vector whose entry would run past the end of the table is flagged as an error.

The result is registered. It appears one cycle after a request, together with a single-cycle valid pulse.

Top module: `rm_addr_gen`

## Requirements
- R1: After reset, valid_o, err_o and addr_o are all zero.
- R2: valid_o is high for exactly the one cycle after each cycle with req_i high, and low otherwise.
- R3: With kind_i = 0 (segment request), addr_o = seg_i * 16 + off_i, taken as a 21-bit sum. Example: 0x07C0:0x0007 gives 0x07C07.
- R4: With a20_en_i = 1, bit 20 of the sum is kept. Example: 0xFFFF:0xFFFF gives 0x10FFEF.
- R5: With a20_en_i = 0, addr_o[20] is zero whatever the carry, and bits 19:0 are unchanged. Example: 0xFFFF:0xFFFF gives 0x0FFEF.
- R6: With kind_i = 1 (vector request), addr_o = vec_i * 4, and seg_i and off_i have no effect.
- R7: A vector request whose 4-byte entry would end above 0x3FF (vec_i >= 256 with the 9-bit default) gives err_o = 1 and addr_o = 0 in the valid cycle.
- R8: err_o is zero for every segment request and in every cycle where valid_o is low.
- R9: addr_o holds its last value in cycles that follow a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, sampled at the rising edge |
| kind_i | input | 1 | Request type: 0 = segment:offset, 1 = interrupt vector |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset within the segment |
| a20_en_i | input | 1 | 1 keeps address bit 20; 0 forces it to zero |
| vec_i | input | 9 | Interrupt vector number |
| addr_o | output | 21 | Registered physical address |
| valid_o | output | 1 | One-cycle pulse that marks a new result |
| err_o | output | 1 | Vector entry lies outside the table; valid with valid_o |

## Verification
The bench exercises the carry into bit 20 with the gate both open and closed.
- A design that drops the carry would return 0x0FFEF for 0xFFFF:0xFFFF even with the gate open.
- A design that forgets the gate would leak 0x10FFEF while the gate is closed.

The bench also uses a segment base with no carry (0xF000:0xFFFF), which should give the same result whatever the gate setting.

For vectors, the bench checks the last in-range entry (vector 255 at 0x3FC) and the first and last out-of-range vectors. A wrong limit compare would either flag vector 255 or pass vector 256. The vector tests are run with junk on the segment and offset inputs, so a wrong mode select shows up as an unexpected address. Idle cycles after each request confirm that valid is a pulse and that the address is held.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  typedef enum logic {
    REQ_SEG = 1'b0,
    REQ_VEC = 1'b1
  } req_kind_e;
endpackage

// File: rtl/rm_seg_adder.sv
module rm_seg_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 21
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] base;

  assign base  = {seg_i, {SHIFT{1'b0}}};
  // carry beyond BASE_W is kept here; gating happens downstream
  assign sum_o = ADDR_W'(base) + ADDR_W'(off_i);
endmodule

// File: rtl/rm_ivt_index.sv
module rm_ivt_index #(
  parameter int VEC_W       = 9,
  parameter int ENTRY_BYTES = 4,
  parameter int IVT_LIMIT   = 'h3FF,
  parameter int ADDR_W      = 21
) (
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam int IDX_W    = VEC_W + ENTRY_SH + 1;
  localparam logic [IDX_W-1:0] LIMIT_V = IDX_W'(IVT_LIMIT);
  localparam logic [IDX_W-1:0] LAST_V  = IDX_W'(ENTRY_BYTES - 1);

  logic [IDX_W-1:0] start_b;
  logic [IDX_W-1:0] end_b;

  assign start_b = IDX_W'(vec_i) << ENTRY_SH;
  assign end_b   = start_b + LAST_V;
  assign err_o   = end_b > LIMIT_V;
  assign addr_o  = err_o ? '0 : ADDR_W'(start_b);
endmodule

// File: rtl/rm_a20_mask.sv
module rm_a20_mask #(
  parameter int ADDR_W   = 21,
  parameter int GATE_BIT = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    if (!en_i) addr_o[GATE_BIT] = 1'b0;
  end
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rm_addr_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int OFF_W       = 16,
  parameter int SHIFT       = 4,
  parameter int VEC_W       = 9,
  parameter int ENTRY_BYTES = 4,
  parameter int IVT_LIMIT   = 'h3FF,
  localparam int ADDR_W     = SEG_W + SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              kind_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              a20_en_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int GATE_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] seg_sum, ivt_addr, raw_addr, gated_addr;
  logic              ivt_err, nxt_err;

  rm_seg_adder #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
  ) i_seg_adder (
    .seg_i(seg_i), .off_i(off_i), .sum_o(seg_sum)
  );

  rm_ivt_index #(
    .VEC_W(VEC_W), .ENTRY_BYTES(ENTRY_BYTES), .IVT_LIMIT(IVT_LIMIT), .ADDR_W(ADDR_W)
  ) i_ivt_index (
    .vec_i(vec_i), .addr_o(ivt_addr), .err_o(ivt_err)
  );

  always_comb begin
    if (req_kind_e'(kind_i) == REQ_VEC) begin
      raw_addr = ivt_addr;
      nxt_err  = ivt_err;
    end else begin
      raw_addr = seg_sum;
      nxt_err  = 1'b0;
    end
  end

  rm_a20_mask #(
    .ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)
  ) i_a20_mask (
    .addr_i(raw_addr), .en_i(a20_en_i), .addr_o(gated_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= req_i;
      err_o   <= req_i & nxt_err;
      if (req_i) addr_o <= gated_addr;
    end
  end
endmodule

// File: rtl/rm_addr_gen_chk.sv
module rm_addr_gen_chk #(
  parameter int VEC_W  = 9,
  parameter int ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              kind_i,
  input logic              a20_en_i,
  input logic [VEC_W-1:0]  vec_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              err_o
);
  assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  assert_gate_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !a20_en_i) |=> !addr_o[ADDR_W-1]);
  assert_err_qualified_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);
  assert_err_seg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !kind_i) |=> !err_o);
  assert_vec_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i && vec_i[VEC_W-1]) |=> (err_o && addr_o == '0));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(addr_o));
endmodule

bind rm_addr_gen rm_addr_gen_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .kind_i(kind_i),
  .a20_en_i(a20_en_i), .vec_i(vec_i), .addr_o(addr_o),
  .valid_o(valid_o), .err_o(err_o)
);

// File: tb/test_rm_addr_gen.sv
module test_rm_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        kind = 1'b0;
  logic [15:0] seg = '0;
  logic [15:0] off = '0;
  logic        a20 = 1'b0;
  logic [8:0]  vec = '0;
  logic [20:0] addr;
  logic        valid;
  logic        err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rm_addr_gen i_rm_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind),
    .seg_i(seg), .off_i(off), .a20_en_i(a20), .vec_i(vec),
    .addr_o(addr), .valid_o(valid), .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // issue one request, sample in the valid cycle, then one idle cycle
  task automatic issue(input logic k, input logic [15:0] s, input logic [15:0] o,
                       input logic g, input logic [8:0] v,
                       output logic [20:0] a, output logic e, output logic vl);
    @(negedge clk);
    kind = k; seg = s; off = o; a20 = g; vec = v; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    a = addr; e = err; vl = valid;
    seg = 16'hA5A5; off = 16'h5A5A; vec = 9'h155; kind = ~k;
    @(negedge clk);
    check("R2 valid drops after pulse", {31'b0, valid}, 32'd0);
    check("R8 err low when idle", {31'b0, err}, 32'd0);
    check("R9 addr held", {11'b0, addr}, {11'b0, a});
  endtask

  function automatic logic [20:0] seg_exp(input logic [15:0] s, input logic [15:0] o, input logic g);
    logic [20:0] r;
    r = {1'b0, s, 4'b0} + {5'b0, o};
    if (!g) r[20] = 1'b0;
    return r;
  endfunction

  task automatic t_seg(input string tag, input logic [15:0] s, input logic [15:0] o, input logic g);
    logic [20:0] a; logic e, vl;
    issue(1'b0, s, o, g, 9'h1FF, a, e, vl);
    check({tag, " valid"}, {31'b0, vl}, 32'd1);
    check({tag, " addr"}, {11'b0, a}, {11'b0, seg_exp(s, o, g)});
    check("R8 no err on segment request", {31'b0, e}, 32'd0);
  endtask

  task automatic t_vec(input string tag, input logic [8:0] v, input logic g);
    logic [20:0] a; logic e, vl; logic bad;
    bad = v >= 9'd256;
    issue(1'b1, 16'hFFFF, 16'hFFFF, g, v, a, e, vl);
    check({tag, " valid"}, {31'b0, vl}, 32'd1);
    check({tag, " err"}, {31'b0, e}, {31'b0, bad});
    check({tag, " addr"}, {11'b0, a}, bad ? 32'd0 : {21'b0, v, 2'b00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid at reset", {31'b0, valid}, 32'd0);
    check("R1 err at reset", {31'b0, err}, 32'd0);
    check("R1 addr at reset", {11'b0, addr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid idle after reset", {31'b0, valid}, 32'd0);

    t_seg("R3 07C0:0007 gate open", 16'h07C0, 16'h0007, 1'b1);
    check("R3 value 0x07C07", {11'b0, addr}, 32'h07C07);
    t_seg("R3 07C0:0007 gate closed", 16'h07C0, 16'h0007, 1'b0);
    t_seg("R3 0000:0000", 16'h0000, 16'h0000, 1'b1);
    t_seg("R3 F000:FFFF no carry", 16'hF000, 16'hFFFF, 1'b0);
    check("R3 value 0xFFFFF", {11'b0, addr}, 32'hFFFFF);
    t_seg("R4 FFFF:FFFF gate open", 16'hFFFF, 16'hFFFF, 1'b1);
    check("R4 value 0x10FFEF", {11'b0, addr}, 32'h10FFEF);
    t_seg("R4 FFFF:0010 first HMA byte", 16'hFFFF, 16'h0010, 1'b1);
    check("R4 value 0x100000", {11'b0, addr}, 32'h100000);
    t_seg("R5 FFFF:FFFF gate closed", 16'hFFFF, 16'hFFFF, 1'b0);
    check("R5 value 0x0FFEF", {11'b0, addr}, 32'h0FFEF);
    t_seg("R5 FFFF:0010 wraps to 0", 16'hFFFF, 16'h0010, 1'b0);
    check("R5 value 0x00000", {11'b0, addr}, 32'h0);

    t_vec("R6 vector 0", 9'd0, 1'b1);
    t_vec("R6 vector 8", 9'd8, 1'b0);
    t_vec("R6 vector 255 last entry", 9'd255, 1'b1);
    check("R6 value 0x3FC", {11'b0, addr}, 32'h3FC);
    t_vec("R7 vector 256 past limit", 9'd256, 1'b1);
    t_vec("R7 vector 511 past limit", 9'd511, 1'b0);

    // back-to-back requests: valid stays high, each result lands one cycle later
    @(negedge clk);
    kind = 1'b0; seg = 16'h1234; off = 16'h0001; a20 = 1'b1; req = 1'b1;
    @(negedge clk);
    check("R2 back-to-back first valid", {31'b0, valid}, 32'd1);
    check("R3 back-to-back first addr", {11'b0, addr}, 32'h12341);
    kind = 1'b1; vec = 9'd3;
    @(negedge clk);
    req = 1'b0;
    check("R2 back-to-back second valid", {31'b0, valid}, 32'd1);
    check("R6 back-to-back vector addr", {11'b0, addr}, 32'h0C);
    @(negedge clk);
    check("R2 valid low after burst", {31'b0, valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule